// File: doc/BRIEF.md
# Bit-Banged Serial EEPROM Responder

This block models a small two-wire serial memory slave. It holds 256 bytes. It does not run from a bus clock of its own. A host register bank writes new SCL and SDA levels and marks each write with a one-cycle strobe. The responder treats each strobed write as one line update and compares it with the levels it stored last. From that comparison it finds start and stop conditions and rising clock edges. It then steps a single bit counter through a command byte, an acknowledge, an address byte and a second acknowledge.

During the address phase of a transfer whose command has the read flag set, the responder drives the read-back SDA level from the most significant bit of a data shift register. That register was loaded from the content array at the end of the previous address phase. A read therefore takes two transfers: the first sets the address, and the second clocks out the byte. There is no repeated start. The content array is filled at reset from a fixed arithmetic pattern, so the expected bytes can be computed.

The host reads back one level, the SDA value the responder stored last. This includes any low it forced for an acknowledge and any data bit it drove.

Top module: `eeprom_responder`

## Requirements
- R1: After reset the read-back SDA is 1. The counter is 0 and no acknowledge is pending, so the block waits for a start condition.
- R2: A start condition is an update where SCL is high both before and after and SDA goes from 1 to 0. It sets the counter to 1 and clears the command register, even in the middle of a transfer.
- R3: A stop condition is an update where SCL is high both before and after and SDA goes from 0 to 1. It changes nothing except the stored line levels. Read-back SDA becomes 1 and the counter keeps its value.
- R4: While the counter is 0 and no acknowledge is pending, any update that is not a start condition leaves the counter and acknowledge state unchanged. Read-back SDA then equals the written SDA.
- R5: A bit is taken only on an update where SCL goes from 0 to 1 and SDA keeps its stored value. If SDA changes in the same update, the bit is dropped and the counter does not advance.
- R6: Bits shift MSB first into the command register for counts 1 to 8. When the count reaches 9, an acknowledge is armed. Bit 0 of the command (1 = read) selects whether the address phase drives data.
- R7: With an acknowledge armed, the next SCL rise forces read-back SDA to 0, whatever the host wrote, and clears the armed flag.
- R8: For counts 9 to 16, each taken bit shifts MSB first into the address register, and the data shift register moves left by one with a 0 filling in. If the read flag is set, read-back SDA on that rise is the data register MSB from before the shift. Otherwise it is the written SDA.
- R9: The rise that takes the eighth address bit loads the data register with the addressed byte, arms an acknowledge and returns the counter to 0.
- R10: The content byte at address a is (a * FILL_MUL + FILL_ADD) mod 256, written at reset. With the defaults FILL_MUL = 37 and FILL_ADD = 91.
- R11: A cycle with the update strobe low changes no state and keeps read-back SDA, whatever the line inputs do.
- R12: On every other update that takes no bit, read-back SDA equals the written SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock of the host register bank |
| rst_n | input | 1 | Synchronous reset, active low |
| lvl_wr | input | 1 | One-cycle strobe: scl_lvl and sda_lvl carry a new line update |
| scl_lvl | input | 1 | Clock line level written by the host |
| sda_lvl | input | 1 | Data line level written by the host |
| sda_rd | output | 1 | Stored data line level seen by the host |

## Verification
The block has only one observable output, so a wrong counter, flag or shift register inside it shows up at the ports only when it changes the read-back level. A miscount in the command phase moves the forced-low acknowledge to a different SCL rise, and this is visible on the very update that should have carried it. A wrong address register or content byte shows up only in the next read transfer, during its address phase, one bit per rise. The bench therefore runs back-to-back write and read transfers, and it compares the read-back level with a behavioural model after every clock.

// File: rtl/eeprom_resp_pkg.sv
// Package: shared widths, line-event type and the content fill rule for
// the bit-banged EEPROM responder. Assumes byte-wide storage.
package eeprom_resp_pkg;

    localparam int BYTE_W   = 8;
    // counter value at which the command byte is complete
    localparam int CMD_DONE = BYTE_W + 1;
    // counter value at which the address byte is complete
    localparam int ADR_DONE = 2 * BYTE_W + 1;
    localparam int CNT_W    = $clog2(ADR_DONE + 1);

    // classification of one host line update
    typedef struct packed {
        logic start;   // SDA fell with SCL high on both sides
        logic stop;    // SDA rose with SCL high on both sides
        logic rise;    // SCL went 0 -> 1
        logic steady;  // SDA kept its stored value
    } line_ev_t;

    // preload pattern of the content array
    function automatic logic [BYTE_W-1:0] fill_byte(input int unsigned a,
                                                    input int unsigned mul,
                                                    input int unsigned add);
        int unsigned v;
        v = a * mul + add;
        return v[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/eeprom_line_watch.sv
// Line watcher: compares the stored SCL/SDA levels with a freshly written
// pair and classifies the update. Purely combinational; assumes the caller
// qualifies the result with its own write strobe.
module eeprom_line_watch
    import eeprom_resp_pkg::*;
(
    input  logic     scl_old,
    input  logic     sda_old,
    input  logic     scl_new,
    input  logic     sda_new,
    output line_ev_t ev
);

    logic scl_held_high;

    // SCL high before and after is the frame for start and stop
    assign scl_held_high = scl_old & scl_new;

    // build the event flags
    always_comb begin
        ev.start  = scl_held_high &  sda_old & ~sda_new;
        ev.stop   = scl_held_high & ~sda_old &  sda_new;
        ev.rise   = ~scl_old & scl_new;
        ev.steady = (sda_old == sda_new);
    end

endmodule

// File: rtl/eeprom_content.sv
// Content array: 2**ADDR_W bytes filled at reset from the package fill
// rule, with a combinational read port. Assumes no write access is needed.
module eeprom_content
    import eeprom_resp_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int unsigned FILL_MUL = 37,
    parameter int unsigned FILL_ADD = 91
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] mem [DEPTH];

    // one preload register per entry
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cell
        // load the pattern value while reset is asserted
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[gi] <= fill_byte(gi, FILL_MUL, FILL_ADD);
            end
        end
    end

    // asynchronous read of the addressed entry
    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/eeprom_bit_seq.sv
// Bit sequencer: holds the stored line levels, the shared tick counter,
// command, address and data shift registers and the acknowledge flag, and
// applies one host update per strobe. Assumes ADDR_W >= 2 and that the
// content read port returns data in the same cycle.
module eeprom_bit_seq
    import eeprom_resp_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic              scl_new,
    input  logic              sda_new,
    input  line_ev_t          ev,
    input  logic [BYTE_W-1:0] rom_data,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              scl_q,
    output logic              sda_q,
    output logic [CNT_W-1:0]  tick_q,
    output logic              ack_q,
    output logic [BYTE_W-1:0] cmd_q
);

    localparam logic [CNT_W-1:0] TICK_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] TICK_CMD  = CNT_W'(CMD_DONE);
    localparam logic [CNT_W-1:0] TICK_ADR  = CNT_W'(ADR_DONE);
    localparam logic [CNT_W-1:0] TICK_LAST = CNT_W'(ADR_DONE - 1);
    localparam logic [CNT_W-1:0] TICK_CLST = CNT_W'(CMD_DONE - 1);

    logic [ADDR_W-1:0] addr_q, addr_n;
    logic [BYTE_W-1:0] data_q, data_n, cmd_n;
    logic [CNT_W-1:0]  tick_n;
    logic              scl_n, sda_n, ack_n;
    logic              awake;
    logic [ADDR_W-1:0] addr_shift;

    // a bit phase or a pending acknowledge keeps the sequencer awake
    assign awake      = (tick_q != '0) | ack_q;
    // address as it would be after taking the current bit
    assign addr_shift = {addr_q[ADDR_W-2:0], sda_new};
    assign rom_addr   = addr_shift;

    // next-state decision for one host update
    always_comb begin
        scl_n  = scl_q;
        sda_n  = sda_q;
        tick_n = tick_q;
        cmd_n  = cmd_q;
        addr_n = addr_q;
        data_n = data_q;
        ack_n  = ack_q;
        if (upd) begin
            scl_n = scl_new;
            sda_n = sda_new;
            if (ev.start) begin
                tick_n = TICK_ONE;
                cmd_n  = '0;
            end else if (!ev.stop && awake && ev.rise) begin
                if (ack_q) begin
                    sda_n = 1'b0;
                    ack_n = 1'b0;
                end else if (ev.steady) begin
                    if (tick_q < TICK_CMD) begin
                        cmd_n  = {cmd_q[BYTE_W-2:0], sda_new};
                        tick_n = tick_q + TICK_ONE;
                        if (tick_q == TICK_CLST) begin
                            ack_n = 1'b1;
                        end
                    end else if (tick_q < TICK_ADR) begin
                        if (cmd_q[0]) begin
                            sda_n = data_q[BYTE_W-1];
                        end
                        addr_n = addr_shift;
                        if (tick_q == TICK_LAST) begin
                            data_n = rom_data;
                            ack_n  = 1'b1;
                            tick_n = '0;
                        end else begin
                            data_n = {data_q[BYTE_W-2:0], 1'b0};
                            tick_n = tick_q + TICK_ONE;
                        end
                    end else begin
                        sda_n = 1'b0;
                    end
                end
            end
        end
    end

    // state registers with synchronous active-low reset to bus idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
            tick_q <= '0;
            cmd_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
            ack_q  <= 1'b0;
        end else begin
            scl_q  <= scl_n;
            sda_q  <= sda_n;
            tick_q <= tick_n;
            cmd_q  <= cmd_n;
            addr_q <= addr_n;
            data_q <= data_n;
            ack_q  <= ack_n;
        end
    end

endmodule

// File: rtl/eeprom_responder.sv
// Top: serial EEPROM responder driven by host-written line levels. Each
// lvl_wr pulse is one line update; sda_rd is the stored SDA level. Assumes
// the host changes SDA only while SCL is low except for start and stop.
module eeprom_responder
    import eeprom_resp_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int unsigned FILL_MUL = 37,
    parameter int unsigned FILL_ADD = 91
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_wr,
    input  logic scl_lvl,
    input  logic sda_lvl,
    output logic sda_rd
);

    line_ev_t          ev;
    logic              line_scl;
    logic              line_sda;
    logic [CNT_W-1:0]  tick_q;
    logic              ack_q;
    logic [BYTE_W-1:0] cmd_q;
    logic [ADDR_W-1:0] rom_addr;
    logic [BYTE_W-1:0] rom_data;

    eeprom_line_watch u_watch (
        .scl_old (line_scl),
        .sda_old (line_sda),
        .scl_new (scl_lvl),
        .sda_new (sda_lvl),
        .ev      (ev)
    );

    eeprom_content #(
        .ADDR_W   (ADDR_W),
        .FILL_MUL (FILL_MUL),
        .FILL_ADD (FILL_ADD)
    ) u_content (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (rom_addr),
        .rd_data (rom_data)
    );

    eeprom_bit_seq #(
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (lvl_wr),
        .scl_new  (scl_lvl),
        .sda_new  (sda_lvl),
        .ev       (ev),
        .rom_data (rom_data),
        .rom_addr (rom_addr),
        .scl_q    (line_scl),
        .sda_q    (line_sda),
        .tick_q   (tick_q),
        .ack_q    (ack_q),
        .cmd_q    (cmd_q)
    );

    // the host sees the stored data line level
    assign sda_rd = line_sda;

endmodule

// File: rtl/eeprom_responder_chk.sv
// Checker: temporal properties of the responder, attached by bind. Assumes
// the sequencer's counter, acknowledge flag and stored SCL are visible.
module eeprom_responder_chk
    import eeprom_resp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              lvl_wr,
    input logic              scl_lvl,
    input logic              sda_lvl,
    input logic              sda_rd,
    input logic              scl_q,
    input logic [CNT_W-1:0]  tick,
    input logic              ack,
    input logic [BYTE_W-1:0] cmd
);

    logic start_upd;
    assign start_upd = lvl_wr & scl_q & scl_lvl & sda_rd & ~sda_lvl;

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl_wr |=> $stable(sda_rd) && $stable(tick) && $stable(ack));

    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_upd |=> (tick == CNT_W'(1)) && (cmd == '0));

    assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_wr && tick == '0 && !ack && !start_upd)
        |=> (tick == '0) && !ack && (sda_rd == $past(sda_lvl)));

    assert_ack_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_wr && ack && !scl_q && scl_lvl) |=> !sda_rd && !ack);

    assert_arm_point_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> (tick == CNT_W'(CMD_DONE)) || (tick == '0));

    assert_tick_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tick < CNT_W'(ADR_DONE));

endmodule

bind eeprom_responder eeprom_responder_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .lvl_wr  (lvl_wr),
    .scl_lvl (scl_lvl),
    .sda_lvl (sda_lvl),
    .sda_rd  (sda_rd),
    .scl_q   (line_scl),
    .tick    (tick_q),
    .ack     (ack_q),
    .cmd     (cmd_q)
);

// File: tb/tb_eeprom_responder.sv
// Bench: behavioural reference model compared every clock, plus directed
// checks on transfers, acknowledges, discards, restarts and stops.
module tb_eeprom_responder;

    logic clk = 1'b0;
    logic rst_n, lvl_wr, scl_lvl, sda_lvl;
    logic sda_rd;

    always #5 clk = ~clk;

    eeprom_responder dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_wr  (lvl_wr),
        .scl_lvl (scl_lvl),
        .sda_lvl (sda_lvl),
        .sda_rd  (sda_rd)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    live  = 0;
    bit    done  = 0;
    string cur_req = "R12";

    // reference model state
    int m_scl, m_sda, m_tick, m_cmd, m_addr, m_data, m_ack, m_ns;

    function automatic int fill(input int a);
        return (a * 37 + 91) % 256;
    endfunction

    // model step on each clock
    always @(posedge clk) begin
        if (!rst_n) begin
            m_scl = 1; m_sda = 1; m_tick = 0; m_cmd = 0;
            m_addr = 0; m_data = 0; m_ack = 0;
            live <= 1'b1;
        end else if (lvl_wr) begin
            m_ns = int'(sda_lvl);
            if (m_scl == 1 && scl_lvl && m_sda != int'(sda_lvl)) begin
                if (!sda_lvl) begin
                    m_tick = 1; m_cmd = 0;
                end
            end else if (m_tick == 0 && m_ack == 0) begin
                m_ns = int'(sda_lvl);
            end else if (m_scl == 0 && scl_lvl) begin
                if (m_ack != 0) begin
                    m_ns = 0; m_ack = 0;
                end else if (m_sda == int'(sda_lvl)) begin
                    if (m_tick < 9) begin
                        m_cmd = (m_cmd * 2 + int'(sda_lvl)) % 256;
                        m_tick++;
                        if (m_tick == 9) m_ack = 1;
                    end else if (m_tick < 17) begin
                        if (m_cmd % 2 == 1) m_ns = (m_data / 128) % 2;
                        m_addr = (m_addr * 2 + int'(sda_lvl)) % 256;
                        m_data = (m_data * 2) % 256;
                        m_tick++;
                        if (m_tick == 17) begin
                            m_data = fill(m_addr); m_ack = 1; m_tick = 0;
                        end
                    end else begin
                        m_ns = 0;
                    end
                end
            end
            m_scl = int'(scl_lvl);
            m_sda = m_ns;
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (live && rst_n && !done) begin
            n_cmp++;
            if (int'(sda_rd) != m_sda) begin
                n_bad++;
                $display("FAIL %s model compare: sda_rd=%0d expected %0d at %0t",
                         cur_req, sda_rd, m_sda, $time);
            end
        end
    end

    task automatic chk(input int act, input int exp, input string req, input string what);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic s, input logic d);
        @(negedge clk);
        lvl_wr = 1'b1; scl_lvl = s; sda_lvl = d;
        @(negedge clk);
        lvl_wr = 1'b0;
    endtask

    task automatic send_bit(input int b, output int got);
        wr(1'b0, b[0]);
        wr(1'b1, b[0]);
        got = int'(sda_rd);
        wr(1'b0, b[0]);
    endtask

    task automatic send_byte(input int v, output int got);
        int g;
        got = 0;
        for (int i = 7; i >= 0; i--) begin
            send_bit((v >> i) & 1, g);
            got = got * 2 + g;
        end
    endtask

    task automatic ack_slot(input string req);
        wr(1'b0, 1'b1);
        wr(1'b1, 1'b1);
        chk(int'(sda_rd), 0, req, "acknowledge forces SDA low");
        wr(1'b0, 1'b1);
    endtask

    task automatic do_start();
        wr(1'b0, 1'b1);
        wr(1'b1, 1'b1);
        wr(1'b1, 1'b0);
    endtask

    task automatic do_stop();
        wr(1'b0, 1'b0);
        wr(1'b1, 1'b0);
        wr(1'b1, 1'b1);
    endtask

    // one full transfer: command, acknowledge, address, acknowledge
    task automatic xfer(input int cmd, input int adr, output int got);
        do_start();
        send_byte(cmd, got);
        ack_slot("R6");
        send_byte(adr, got);
        ack_slot("R9");
        do_stop();
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int got, g;
        rst_n = 1'b0; lvl_wr = 1'b0; scl_lvl = 1'b1; sda_lvl = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        cur_req = "R1";
        chk(int'(sda_rd), 1, "R1", "read-back after reset");

        // R11: inputs move without the strobe
        cur_req = "R11";
        scl_lvl = 1'b0; sda_lvl = 1'b0;
        repeat (4) @(negedge clk);
        scl_lvl = 1'b1;
        repeat (2) @(negedge clk);
        chk(int'(sda_rd), 1, "R11", "no update without strobe");

        // R4: activity before any start is ignored
        cur_req = "R4";
        wr(1'b0, 1'b0);
        wr(1'b1, 1'b0);
        chk(int'(sda_rd), 0, "R4", "idle echo of written SDA");
        wr(1'b0, 1'b1);
        wr(1'b1, 1'b1);
        chk(int'(sda_rd), 1, "R4", "idle rise takes no bit");

        // write-flag transfer sets address 0x5C; host bits echo (R8, R12)
        cur_req = "R8";
        do_start();
        send_byte(8'hA0, got);
        chk(got, 8'hA0, "R12", "command bits echo");
        ack_slot("R6");
        send_byte(8'h5C, got);
        chk(got, 8'h5C, "R8", "write flag leaves SDA to host");
        ack_slot("R9");
        do_stop();
        chk(int'(sda_rd), 1, "R3", "stop leaves SDA high");

        // read transfers: each returns the byte addressed by the previous one
        cur_req = "R10";
        xfer(8'hA1, 8'hFF, got);
        do_start(); send_byte(8'hA1, g); ack_slot("R6");
        send_byte(8'h00, got);
        chk(got, fill(8'hFF), "R10", "byte at top address 0xFF");
        ack_slot("R9"); do_stop();
        do_start(); send_byte(8'hA1, g); ack_slot("R6");
        send_byte(8'h11, got);
        chk(got, fill(8'h00), "R10", "byte at address 0x00");
        ack_slot("R9"); do_stop();

        // R5: a rise with SDA moving is dropped
        cur_req = "R5";
        do_start();
        wr(1'b0, 1'b1);
        wr(1'b1, 1'b0);
        chk(int'(sda_rd), 0, "R5", "dropped rise stores written SDA");
        wr(1'b0, 1'b0);
        send_byte(8'hA1, g);
        ack_slot("R5");
        send_byte(8'h22, got);
        chk(got, fill(8'h11), "R5", "alignment after dropped bit");
        ack_slot("R9"); do_stop();

        // R2: restart in the middle of an address phase
        cur_req = "R2";
        do_start(); send_byte(8'hA0, g); ack_slot("R6");
        send_bit(1, g); send_bit(0, g); send_bit(1, g);
        wr(1'b0, 1'b1);
        wr(1'b1, 1'b1);
        wr(1'b1, 1'b0);
        send_byte(8'hA1, g);
        ack_slot("R2");
        send_byte(8'h33, got);
        chk(got, (fill(8'h22) * 16) % 256, "R2", "restart keeps shifted data");
        ack_slot("R9"); do_stop();

        // R3: a stop inside the command phase keeps the counter
        cur_req = "R3";
        do_start();
        send_bit(1, g); send_bit(0, g); send_bit(1, g);
        do_stop();
        chk(int'(sda_rd), 1, "R3", "stop mid-command SDA high");
        send_bit(0, g); send_bit(0, g); send_bit(0, g); send_bit(1, g);
        ack_slot("R3");
        send_byte(8'h44, got);
        chk(got, fill(8'h33), "R3", "counter survived stop");
        ack_slot("R9"); do_stop();

        repeat (3) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule